// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher

This block watches the time of day produced by a calendar counter elsewhere on the chip. On every one-second tick it compares that time against four programmed alarm fields: seconds, minutes, hours and day-or-date. When the programmed condition is met, it sets an alarm flag. The flag drives an active-low interrupt line when the alarm is enabled.

Each alarm field carries a mask bit in its top position, and together the mask bits set the repeat rate. A masked seconds field fires every second. Masking a higher field while keeping the lower ones compared gives once a minute, once an hour or once a day. With nothing masked the alarm needs a full match, including either the day of the week or the date of the month. A select bit in the day/date field chooses between those two.

Software reaches the block through a small register port. It programs the four alarm fields and an enable bit through that port. Reading the status register returns the flag and clears it.

Top module: `alarm_match_top`

## Requirements
- R1: After reset every register reads 0 and irqN is 1.
- R2: If alarm-seconds bit 7 (mask) is 1, every tick sets the flag.
- R3: If seconds is unmasked and any higher field is masked (bit 7 of minutes set), a tick sets the flag only when curSec equals alarm-seconds bits 6:0. The masks of the hours and day/date fields do not matter in this case.
- R4: If seconds and minutes are unmasked and hours bit 7 is 1, a tick sets the flag only when seconds and minutes (bits 6:0) both match.
- R5: If seconds, minutes and hours are unmasked and day/date bit 7 is 1, a tick sets the flag only when seconds, minutes and hours (bits 5:0) all match.
- R6: If no field is masked, seconds, minutes and hours must all match, and the day/date field must match as well. That field is compared against curDate when its bit 6 is 0 and against curDay when its bit 6 is 1, using bits 5:0.
- R7: A match is only evaluated in a cycle where secTick is 1. The flag is set at the clock edge that ends that cycle; without a tick the flag never sets.
- R8: Reading offset 5 returns the flag in bit 0 and clears it at the ending edge. If a match is taken in the same cycle, the flag stays set.
- R9: irqN is 0 exactly when the flag is set and control bit 0 (offset 4) is 1. The enable bit never changes the flag.
- R10: The register map is: offsets 0 to 3 for alarm seconds, minutes, hours and day/date (all 8 bits read back); offset 4 for control (only bit 0 is kept); offset 5 for status (read-only). Writes to offsets 5 to 7 are ignored, and offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| regAddr | input | 3 | register offset |
| regWrEn | input | 1 | write strobe |
| regWrData | input | 8 | write data |
| regRdEn | input | 1 | read strobe (clear-on-read side effect) |
| regRdData | output | 8 | read data, combinational from regAddr |
| secTick | input | 1 | one-cycle one-second strobe |
| curSec | input | 7 | current seconds, BCD |
| curMin | input | 7 | current minutes, BCD |
| curHour | input | 6 | current hours, BCD 00-23 |
| curDay | input | 3 | current day of week, 1-7 |
| curDate | input | 6 | current date, BCD 01-31 |
| irqN | output | 1 | active-low alarm interrupt |

## Verification
Two events can fall in the same clock cycle: a status read that clears the flag, and a tick whose match sets it. The bench provokes this by holding secTick high while it reads offset 5 with the every-second rate selected. The read in that cycle must return the old flag. A second read must still see the flag set, and a third read must see it cleared, which shows that the set won the collision and the clear was not lost on later reads.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int N_FLD  = 4;

  localparam logic [ADDR_W-1:0] OFF_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_DAY  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd5;

  localparam int MASK_BIT = DATA_W - 1;
  localparam int SEL_BIT  = DATA_W - 2;

  typedef struct packed {
    logic wrSec;
    logic wrMin;
    logic wrHour;
    logic wrDay;
    logic wrCtl;
    logic clrFlag;
  } almStrobe_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output almStrobe_t        strb
);
  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regAddr)
        OFF_SEC:  strb.wrSec  = 1'b1;
        OFF_MIN:  strb.wrMin  = 1'b1;
        OFF_HOUR: strb.wrHour = 1'b1;
        OFF_DAY:  strb.wrDay  = 1'b1;
        OFF_CTL:  strb.wrCtl  = 1'b1;
        default:  ;
      endcase
    end
    strb.clrFlag = regRdEn && (regAddr == OFF_STAT);
  end

  // R10: at most one register is written per cycle
  a_r10_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSec, strb.wrMin, strb.wrHour, strb.wrDay, strb.wrCtl}));
endmodule

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  almStrobe_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              secTick,
  input  logic [6:0]        curSec,
  input  logic [6:0]        curMin,
  input  logic [5:0]        curHour,
  input  logic [2:0]        curDay,
  input  logic [5:0]        curDate,
  output logic              alarmFlag,
  output logic              alarmEn
);
  localparam logic [DATA_W-1:0] VALID [N_FLD] = '{8'h7F, 8'h7F, 8'h3F, 8'h3F};

  logic [DATA_W-1:0] almReg [N_FLD];
  logic [DATA_W-1:0] curVec [N_FLD];
  logic [N_FLD-1:0]  fldEq;
  logic [N_FLD-1:0]  fldMask;
  logic              rateHit;
  logic              matchHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_FLD; i++) almReg[i] <= '0;
      alarmEn <= 1'b0;
    end else begin
      if (strb.wrSec)  almReg[0] <= regWrData;
      if (strb.wrMin)  almReg[1] <= regWrData;
      if (strb.wrHour) almReg[2] <= regWrData;
      if (strb.wrDay)  almReg[3] <= regWrData;
      if (strb.wrCtl)  alarmEn   <= regWrData[0];
    end
  end

  always_comb begin
    curVec[0] = {1'b0, curSec};
    curVec[1] = {1'b0, curMin};
    curVec[2] = {2'b0, curHour};
    curVec[3] = almReg[3][SEL_BIT] ? {5'b0, curDay} : {2'b0, curDate};
  end

  for (genvar g = 0; g < N_FLD; g++) begin : g_fld
    assign fldEq[g]   = ((almReg[g] ^ curVec[g]) & VALID[g]) == '0;
    assign fldMask[g] = almReg[g][MASK_BIT];
  end

  always_comb begin
    if (fldMask[0])      rateHit = 1'b1;
    else if (fldMask[1]) rateHit = fldEq[0];
    else if (fldMask[2]) rateHit = &fldEq[1:0];
    else if (fldMask[3]) rateHit = &fldEq[2:0];
    else                 rateHit = &fldEq;
  end

  assign matchHit = secTick && rateHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              alarmFlag <= 1'b0;
    else if (matchHit)      alarmFlag <= 1'b1;
    else if (strb.clrFlag)  alarmFlag <= 1'b0;
  end

  always_comb begin
    case (regAddr)
      OFF_SEC:  regRdData = almReg[0];
      OFF_MIN:  regRdData = almReg[1];
      OFF_HOUR: regRdData = almReg[2];
      OFF_DAY:  regRdData = almReg[3];
      OFF_CTL:  regRdData = {{(DATA_W-1){1'b0}}, alarmEn};
      OFF_STAT: regRdData = {{(DATA_W-1){1'b0}}, alarmFlag};
      default:  regRdData = '0;
    endcase
  end

  // R7: a flag rise always follows a tick cycle
  a_r7_rise_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(secTick));
  // R2: masked seconds fires on every tick
  a_r2_every_tick: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && almReg[0][MASK_BIT]) |=> alarmFlag);
  // R8: a status read with no tick clears the flag
  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && !secTick) |=> !alarmFlag);
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              regRdEn,
  output logic [7:0]        regRdData,
  input  logic              secTick,
  input  logic [6:0]        curSec,
  input  logic [6:0]        curMin,
  input  logic [5:0]        curHour,
  input  logic [2:0]        curDay,
  input  logic [5:0]        curDate,
  output logic              irqN
);
  almStrobe_t strb;
  logic       alarmFlag;
  logic       alarmEn;

  alarm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .strb(strb)
  );

  alarm_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .secTick(secTick),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDay(curDay), .curDate(curDate),
    .alarmFlag(alarmFlag), .alarmEn(alarmEn)
  );

  assign irqN = ~(alarmFlag & alarmEn);

  // R9: interrupt only asserted while a flag is pending
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> alarmFlag);
endmodule

// File: tb/alarm_match_top_tb_top.sv
module alarm_match_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {alarm sec, min, hour, day/date, expected flag}; current time 12:45:30, day 3, date 17
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h80, 8'h00, 8'h00, 8'h00, 8'h01},  // R2 every second
    {8'h30, 8'h80, 8'h00, 8'h00, 8'h01},  // R3 seconds match
    {8'h31, 8'h80, 8'h00, 8'h00, 8'h00},  // R3 seconds differ
    {8'h30, 8'h45, 8'h80, 8'h00, 8'h01},  // R4 sec+min match
    {8'h30, 8'h44, 8'h80, 8'h00, 8'h00},  // R4 minutes differ
    {8'h30, 8'h45, 8'h12, 8'h80, 8'h01},  // R5 time of day match
    {8'h30, 8'h45, 8'h13, 8'h80, 8'h00},  // R5 hour differs
    {8'h30, 8'h45, 8'h12, 8'h17, 8'h01},  // R6 date match
    {8'h30, 8'h45, 8'h12, 8'h18, 8'h00},  // R6 date differs
    {8'h30, 8'h45, 8'h12, 8'h43, 8'h01},  // R6 day-of-week match
    {8'h30, 8'h45, 8'h12, 8'h57, 8'h00},  // R6 day mode, day differs
    {8'h30, 8'h80, 8'h80, 8'h80, 8'h01}   // R3 extra masks ignored
  };

  logic clk = 0, rstN = 0;
  logic [2:0] regAddr = '0;
  logic regWrEn = 0, regRdEn = 0, secTick = 0;
  logic [7:0] regWrData = '0, regRdData;
  logic [6:0] curSec = 7'h30, curMin = 7'h45;
  logic [5:0] curHour = 6'h12, curDate = 6'h17;
  logic [2:0] curDay = 3'd3;
  logic irqN;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_top dut_i (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1; #1 d = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1;
    @(negedge clk); secTick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #1 check("R1 irqN", {7'b0, irqN}, 8'h01);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v); check("R1 reset read", v, 8'h00);
    end
    // vector table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd0, VEC[i][39:32]); wr(3'd1, VEC[i][31:24]);
      wr(3'd2, VEC[i][23:16]); wr(3'd3, VEC[i][15:8]);
      rd(3'd5, v);
      tick();
      rd(3'd5, v);
      check($sformatf("R2-6 vector %0d", i), v, VEC[i][7:0]);
    end
    // R7 no tick, no flag
    wr(3'd0, 8'h80); rd(3'd5, v);
    repeat (5) @(negedge clk);
    rd(3'd5, v); check("R7 no tick", v, 8'h00);
    // R8 read clears
    tick(); rd(3'd5, v); check("R8 read returns flag", v, 8'h01);
    rd(3'd5, v); check("R8 cleared after read", v, 8'h00);
    // R8 collision: tick and status read in the same cycle
    tick();
    @(negedge clk); regAddr = 3'd5; regRdEn = 1; secTick = 1; #1 v = regRdData;
    check("R8 collision old value", v, 8'h01);
    @(negedge clk); regRdEn = 0; secTick = 0;
    rd(3'd5, v); check("R8 set wins", v, 8'h01);
    rd(3'd5, v); check("R8 then clears", v, 8'h00);
    // R9 enable gating
    tick();
    #1 check("R9 disabled irq high", {7'b0, irqN}, 8'h01);
    wr(3'd4, 8'hFF);
    #1 check("R9 enabled irq low", {7'b0, irqN}, 8'h00);
    rd(3'd4, v); check("R10 control keeps bit0", v, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd5, v); check("R9 enable leaves flag", v, 8'h01);
    wr(3'd4, 8'h01);
    #1 check("R9 irq high after clear", {7'b0, irqN}, 8'h01);
    // R10 map
    wr(3'd0, 8'h5A); rd(3'd0, v); check("R10 readback sec", v, 8'h5A);
    wr(3'd3, 8'hC9); rd(3'd3, v); check("R10 readback day", v, 8'hC9);
    wr(3'd5, 8'hFF); rd(3'd5, v); check("R10 status write ignored", v, 8'h00);
    wr(3'd6, 8'hA5); rd(3'd6, v); check("R10 offset 6 reads 0", v, 8'h00);
    wr(3'd7, 8'hA5); rd(3'd0, v); check("R10 offset 7 write ignored", v, 8'h5A);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule